// File: doc/BRIEF.md
# Serial Link Power-Up Sequencer

This block brings up and shuts down a point-to-point serial link that has one clock line and two data lines. The master side acts on an active-low power-down input. When the input is released, the master counts a fixed lock interval for its clock multiplier. It then drives a three-step calibration preamble and settles into continuous clock toggling. In that idle state it can also forward transfer bits onto the data lines. The slave side watches the clock line. It pulses a calibration latch at the end of the first preamble step and starts a divided reference clock once toggling has run for a while. A fixed number of cycles later it raises a power-good output.

Each line is modelled as a two-bit current state rather than a real analog level. The clock-multiplier lock is a fixed cycle count. The top holds both sides, and the slave's clock-line input is a separate port, so an integration can loop it back, cut it or hold it stuck. While the slave is not up, its parallel bus outputs are held at parked values. Once it is up, they pass through from the link decoder.

Top module: `lnk_pwrseq`

## Requirements
- R1: In reset, the three master lines are off, `m_phase` is OFF (0), `m_quiet_ok` is low, `slv_pgood` and `slv_refclk` are low, and the slave bus is parked.
- R2: While `pd_n` is low, all master lines read off in the same cycle, and `m_phase` is OFF from the next cycle. Dropping `pd_n` during the preamble aborts it, and a later release restarts the lock count from zero.
- R3: Line states are encoded off=2'b00, low=2'b01, high=2'b10. After `pd_n` rises, the lines stay off for LOCK_CYC clock edges, and the clock line reads low just after edge LOCK_CYC.
- R4: During the preamble (`m_phase` LINKUP = 1), the clock line is low for PRE_LEN cycles, then high for PRE_LEN cycles with both data lines off, then low for PRE_LEN cycles with both data lines low.
- R5: After the preamble, `m_phase` is IDLE (2). The clock line starts high and inverts every MC_HALF cycles, and both data lines are low.
- R6: In IDLE, `act_valid` high makes `m_phase` ACTIVE (3) one cycle later. The data lines then carry `act_md`: bit 0 to data line 0, bit 1 to data line 1, with 1 giving high and 0 giving low.
- R7: `m_quiet_ok` is low while a transfer is active. It goes high once QUIET_MC rising clock-line edges have passed with no transfer.
- R8: `slv_cal_latch` pulses for exactly one cycle, after the slave sees the low-to-high clock-line transition that ends the first preamble step.
- R9: The slave starts `slv_refclk` on the SLV_CLK_MC-th rising clock-line edge after the preamble. It raises `slv_pgood` SLV_PG_WAIT cycles after that.
- R10: An off clock line drops `slv_pgood` in the same cycle. LOSS_CYC cycles without a clock-line edge also take the slave down.
- R11: While `slv_pgood` is low, the slave bus reads data and A/D low and both chip selects and both strobes high. While it is high, the bus outputs follow the `up_*` inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Master power-down, active low |
| act_valid | input | 1 | Transfer bits present on act_md |
| act_md | input | 2 | Bits for the two data lines |
| m_mc | output | 2 | Master clock-line state |
| m_md0 | output | 2 | Master data line 0 state |
| m_md1 | output | 2 | Master data line 1 state |
| m_phase | output | 2 | Link phase: 0 OFF, 1 LINKUP, 2 IDLE, 3 ACTIVE |
| m_quiet_ok | output | 1 | Enough idle clock cycles for a safe power-down |
| slv_mc_in | input | 2 | Clock-line state seen by the slave |
| up_data | input | DATA_W | Slave bus data from the decoder |
| up_ad | input | 1 | Address/data select from the decoder |
| up_cs1_n | input | 1 | Chip select 1 from the decoder |
| up_cs2_n | input | 1 | Chip select 2 from the decoder |
| up_rd_st | input | 1 | Read strobe from the decoder |
| up_wr_st | input | 1 | Write strobe from the decoder |
| slv_cal_latch | output | 1 | Calibration latch pulse |
| slv_refclk | output | 1 | Divided reference clock |
| slv_pgood | output | 1 | Slave link up |
| slv_data | output | DATA_W | Slave bus data |
| slv_ad | output | 1 | Slave address/data select |
| slv_cs1_n | output | 1 | Slave chip select 1 |
| slv_cs2_n | output | 1 | Slave chip select 2 |
| slv_rd_st | output | 1 | Slave read strobe |
| slv_wr_st | output | 1 | Slave write strobe |

## Verification
The bench shortens LOCK_CYC to 64 and keeps the default preamble length of 11, the default slave counts of 7 and 17, and the default loss window of 8. With the shorter lock, every preamble step boundary, the calibration pulse and the power-good edge can be checked at their exact cycles in several separate bring-ups. Those bring-ups cover an abort in the middle of the preamble, a stuck clock line and a power-down from the fully up state. MC_HALF of 1 makes the clock line invert every cycle, so the quiet-window and loss checks run in a few dozen cycles.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    typedef enum logic [1:0] {
        LN_OFF = 2'b00,
        LN_LO  = 2'b01,
        LN_HI  = 2'b10
    } line_e;

    typedef enum logic [1:0] {
        PH_OFF    = 2'b00,
        PH_LINKUP = 2'b01,
        PH_IDLE   = 2'b10,
        PH_ACTIVE = 2'b11
    } phase_e;

    typedef struct packed {
        line_e mc;
        line_e md0;
        line_e md1;
    } lines_t;

    typedef struct packed {
        logic ad;
        logic cs1_n;
        logic cs2_n;
        logic rd_st;
        logic wr_st;
    } busctl_t;

    localparam lines_t LINES_DARK = '{mc: LN_OFF, md0: LN_OFF, md1: LN_OFF};
    localparam busctl_t BUSCTL_PARKED = '{ad: 1'b0, cs1_n: 1'b1, cs2_n: 1'b1,
                                         rd_st: 1'b1, wr_st: 1'b1};

    function automatic line_e bit_to_line(input logic b);
        return b ? LN_HI : LN_LO;
    endfunction

    function automatic line_e line_flip(input line_e l);
        return (l == LN_HI) ? LN_LO : LN_HI;
    endfunction

    function automatic logic line_rise(input line_e prev, input line_e cur);
        return (prev == LN_LO) && (cur == LN_HI);
    endfunction

endpackage

// File: rtl/lnk_mst_seq.sv
module lnk_mst_seq
    import lnk_pkg::*;
#(
    parameter int LOCK_CYC = 4096,
    parameter int PRE_LEN  = 11,
    parameter int MC_HALF  = 1,
    parameter int QUIET_MC = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pd_n,
    input  logic       act_valid,
    input  logic [1:0] act_md,
    output lines_t     lines,
    output phase_e     phase,
    output logic       quiet_ok
);

    localparam int CW = $clog2(LOCK_CYC + PRE_LEN + 1);
    localparam int HW = (MC_HALF > 1) ? $clog2(MC_HALF) : 1;
    localparam int QW = $clog2(QUIET_MC + 1);
    localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYC - 1);
    localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_LEN - 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(MC_HALF - 1);
    localparam logic [QW-1:0] QUIET_MAX = QW'(QUIET_MC);

    typedef enum logic [2:0] {
        MS_LOCK, MS_PLO, MS_PHI, MS_PZR, MS_RUN
    } mst_e;

    mst_e           st;
    logic [CW-1:0]  cnt;
    logic [HW-1:0]  hcnt;
    logic [QW-1:0]  quiet;
    logic           act_q;
    lines_t         drv;

    always_ff @(posedge clk) begin
        if (rst || !pd_n) begin
            st    <= MS_LOCK;
            cnt   <= '0;
            hcnt  <= '0;
            quiet <= '0;
            act_q <= 1'b0;
            drv   <= LINES_DARK;
        end else begin
            case (st)
                MS_LOCK: begin
                    if (cnt == LOCK_LAST) begin
                        st     <= MS_PLO;
                        cnt    <= '0;
                        drv.mc <= LN_LO;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                MS_PLO: begin
                    if (cnt == PRE_LAST) begin
                        st     <= MS_PHI;
                        cnt    <= '0;
                        drv.mc <= LN_HI;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                MS_PHI: begin
                    if (cnt == PRE_LAST) begin
                        st      <= MS_PZR;
                        cnt     <= '0;
                        drv.mc  <= LN_LO;
                        drv.md0 <= LN_LO;
                        drv.md1 <= LN_LO;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                MS_PZR: begin
                    if (cnt == PRE_LAST) begin
                        st     <= MS_RUN;
                        cnt    <= '0;
                        hcnt   <= '0;
                        drv.mc <= LN_HI;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                MS_RUN: begin
                    act_q   <= act_valid;
                    drv.md0 <= act_valid ? bit_to_line(act_md[0]) : LN_LO;
                    drv.md1 <= act_valid ? bit_to_line(act_md[1]) : LN_LO;
                    if (hcnt == HALF_LAST) begin
                        hcnt   <= '0;
                        drv.mc <= line_flip(drv.mc);
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                    if (act_valid) begin
                        quiet <= '0;
                    end else if (hcnt == HALF_LAST && drv.mc == LN_LO
                                 && quiet != QUIET_MAX) begin
                        quiet <= quiet + 1'b1;
                    end
                end
                default: st <= MS_LOCK;
            endcase
        end
    end

    always_comb begin
        lines = pd_n ? drv : LINES_DARK;
        if (!pd_n) begin
            phase = PH_OFF;
        end else begin
            case (st)
                MS_LOCK:                  phase = PH_OFF;
                MS_PLO, MS_PHI, MS_PZR:   phase = PH_LINKUP;
                default:                  phase = act_q ? PH_ACTIVE : PH_IDLE;
            endcase
        end
        quiet_ok = pd_n && (st == MS_RUN) && !act_q && (quiet == QUIET_MAX);
    end

endmodule

// File: rtl/lnk_refdiv.sv
module lnk_refdiv #(
    parameter int REF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic ref_out
);

    localparam int HALF = (REF_DIV / 2 > 0) ? REF_DIV / 2 : 1;
    localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DW-1:0] DLAST = DW'(HALF - 1);

    logic [DW-1:0] dcnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            dcnt    <= '0;
            ref_out <= 1'b0;
        end else if (dcnt == DLAST) begin
            dcnt    <= '0;
            ref_out <= !ref_out;
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end

endmodule

// File: rtl/lnk_slv_mon.sv
module lnk_slv_mon
    import lnk_pkg::*;
#(
    parameter int SLV_CLK_MC  = 7,
    parameter int SLV_PG_WAIT = 17,
    parameter int LOSS_CYC    = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  line_e mc_in,
    output logic  cal_latch,
    output logic  clk_en,
    output logic  pgood
);

    localparam int SW = $clog2(SLV_CLK_MC + SLV_PG_WAIT + 1);
    localparam int LW = $clog2(LOSS_CYC + 1);
    localparam logic [SW-1:0] MC_LAST   = SW'(SLV_CLK_MC - 1);
    localparam logic [SW-1:0] WAIT_LAST = SW'(SLV_PG_WAIT - 1);
    localparam logic [LW-1:0] LOSS_LAST = LW'(LOSS_CYC - 1);

    typedef enum logic [2:0] {
        SS_DOWN, SS_CALLO, SS_CALHI, SS_ZERO, SS_COUNT, SS_CLK, SS_UP
    } slv_e;

    slv_e          st;
    line_e         prev;
    logic [SW-1:0] cnt;
    logic [LW-1:0] quiet_cnt;
    logic          edge_seen;
    logic          tracking;

    assign edge_seen = (prev != LN_OFF) && (mc_in != prev);
    assign tracking  = (st == SS_COUNT) || (st == SS_CLK) || (st == SS_UP);

    always_ff @(posedge clk) begin
        if (rst || mc_in == LN_OFF) begin
            st        <= SS_DOWN;
            prev      <= LN_OFF;
            cnt       <= '0;
            quiet_cnt <= '0;
            cal_latch <= 1'b0;
        end else begin
            prev      <= mc_in;
            cal_latch <= (st == SS_CALLO) && (mc_in == LN_HI);
            if (tracking && !edge_seen && quiet_cnt == LOSS_LAST) begin
                st        <= SS_DOWN;
                cnt       <= '0;
                quiet_cnt <= '0;
            end else begin
                if (tracking) begin
                    quiet_cnt <= edge_seen ? '0 : quiet_cnt + 1'b1;
                end
                case (st)
                    SS_DOWN:  if (mc_in == LN_LO) st <= SS_CALLO;
                    SS_CALLO: if (mc_in == LN_HI) st <= SS_CALHI;
                    SS_CALHI: if (mc_in == LN_LO) st <= SS_ZERO;
                    SS_ZERO: begin
                        if (mc_in == LN_HI) begin
                            st        <= SS_COUNT;
                            cnt       <= SW'(1);
                            quiet_cnt <= '0;
                        end
                    end
                    SS_COUNT: begin
                        if (line_rise(prev, mc_in)) begin
                            if (cnt == MC_LAST) begin
                                st  <= SS_CLK;
                                cnt <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    SS_CLK: begin
                        if (cnt == WAIT_LAST) begin
                            st  <= SS_UP;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= st;
                endcase
            end
        end
    end

    assign clk_en = (st == SS_CLK) || (st == SS_UP);
    assign pgood  = (st == SS_UP) && (mc_in != LN_OFF);

endmodule

// File: rtl/lnk_pwrseq.sv
module lnk_pwrseq
    import lnk_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int LOCK_CYC    = 4096,
    parameter int PRE_LEN     = 11,
    parameter int MC_HALF     = 1,
    parameter int QUIET_MC    = 5,
    parameter int SLV_CLK_MC  = 7,
    parameter int SLV_PG_WAIT = 17,
    parameter int LOSS_CYC    = 8,
    parameter int REF_DIV     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_n,
    input  logic              act_valid,
    input  logic [1:0]        act_md,
    output logic [1:0]        m_mc,
    output logic [1:0]        m_md0,
    output logic [1:0]        m_md1,
    output logic [1:0]        m_phase,
    output logic              m_quiet_ok,
    input  logic [1:0]        slv_mc_in,
    input  logic [DATA_W-1:0] up_data,
    input  logic              up_ad,
    input  logic              up_cs1_n,
    input  logic              up_cs2_n,
    input  logic              up_rd_st,
    input  logic              up_wr_st,
    output logic              slv_cal_latch,
    output logic              slv_refclk,
    output logic              slv_pgood,
    output logic [DATA_W-1:0] slv_data,
    output logic              slv_ad,
    output logic              slv_cs1_n,
    output logic              slv_cs2_n,
    output logic              slv_rd_st,
    output logic              slv_wr_st
);

    lines_t  mst_lines;
    phase_e  mst_phase;
    logic    clk_en;
    busctl_t ctl_in;
    busctl_t ctl_out;

    lnk_mst_seq #(
        .LOCK_CYC (LOCK_CYC),
        .PRE_LEN  (PRE_LEN),
        .MC_HALF  (MC_HALF),
        .QUIET_MC (QUIET_MC)
    ) u_mst (
        .clk       (clk),
        .rst       (rst),
        .pd_n      (pd_n),
        .act_valid (act_valid),
        .act_md    (act_md),
        .lines     (mst_lines),
        .phase     (mst_phase),
        .quiet_ok  (m_quiet_ok)
    );

    assign m_mc    = mst_lines.mc;
    assign m_md0   = mst_lines.md0;
    assign m_md1   = mst_lines.md1;
    assign m_phase = mst_phase;

    lnk_slv_mon #(
        .SLV_CLK_MC  (SLV_CLK_MC),
        .SLV_PG_WAIT (SLV_PG_WAIT),
        .LOSS_CYC    (LOSS_CYC)
    ) u_slv (
        .clk       (clk),
        .rst       (rst),
        .mc_in     (line_e'(slv_mc_in)),
        .cal_latch (slv_cal_latch),
        .clk_en    (clk_en),
        .pgood     (slv_pgood)
    );

    lnk_refdiv #(
        .REF_DIV (REF_DIV)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .en      (clk_en),
        .ref_out (slv_refclk)
    );

    assign ctl_in = '{ad: up_ad, cs1_n: up_cs1_n, cs2_n: up_cs2_n,
                      rd_st: up_rd_st, wr_st: up_wr_st};

    always_comb begin
        ctl_out  = slv_pgood ? ctl_in : BUSCTL_PARKED;
        slv_data = slv_pgood ? up_data : '0;
    end

    assign slv_ad    = ctl_out.ad;
    assign slv_cs1_n = ctl_out.cs1_n;
    assign slv_cs2_n = ctl_out.cs2_n;
    assign slv_rd_st = ctl_out.rd_st;
    assign slv_wr_st = ctl_out.wr_st;

endmodule

// File: rtl/lnk_pwrseq_chk.sv
module lnk_pwrseq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          pd_n,
    input logic          act_valid,
    input logic [1:0]    m_mc,
    input logic [1:0]    m_md0,
    input logic [1:0]    m_md1,
    input logic [1:0]    m_phase,
    input logic [1:0]    slv_mc_in,
    input logic          slv_cal_latch,
    input logic          slv_pgood,
    input logic [DW-1:0] slv_data,
    input logic          slv_cs1_n,
    input logic          slv_cs2_n
);

    // R2: power-down forces the OFF phase on the next cycle
    p_pd_off_r2: assert property (@(posedge clk) disable iff (rst)
        !pd_n |=> (m_phase == 2'b00));

    // R3: the clock line never carries the unused encoding
    p_mc_legal_r3: assert property (@(posedge clk) disable iff (rst)
        m_mc != 2'b11);

    // R4: the final preamble step drives both data lines low
    p_zero_step_r4: assert property (@(posedge clk) disable iff (rst)
        (m_phase == 2'b01 && m_mc == 2'b01 && $past(m_mc) == 2'b10)
        |-> (m_md0 == 2'b01 && m_md1 == 2'b01));

    // R5: idle keeps both data lines low
    p_idle_md_low_r5: assert property (@(posedge clk) disable iff (rst)
        (m_phase == 2'b10) |-> (m_md0 == 2'b01 && m_md1 == 2'b01));

    // R6: ACTIVE only follows a cycle with act_valid
    p_active_src_r6: assert property (@(posedge clk) disable iff (rst)
        (pd_n && $past(pd_n) && m_phase == 2'b11) |-> $past(act_valid));

    // R8: calibration latch is a single-cycle pulse
    p_cal_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        slv_cal_latch |=> !slv_cal_latch);

    // R10: slave is never up on a dark clock line
    p_pgood_mc_r10: assert property (@(posedge clk) disable iff (rst)
        slv_pgood |-> (slv_mc_in != 2'b00));

    // R11: the bus is parked while the slave is down
    p_parked_r11: assert property (@(posedge clk) disable iff (rst)
        !slv_pgood |-> (slv_data == '0 && slv_cs1_n && slv_cs2_n));

endmodule

bind lnk_pwrseq lnk_pwrseq_chk #(.DW(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pd_n          (pd_n),
    .act_valid     (act_valid),
    .m_mc          (m_mc),
    .m_md0         (m_md0),
    .m_md1         (m_md1),
    .m_phase       (m_phase),
    .slv_mc_in     (slv_mc_in),
    .slv_cal_latch (slv_cal_latch),
    .slv_pgood     (slv_pgood),
    .slv_data      (slv_data),
    .slv_cs1_n     (slv_cs1_n),
    .slv_cs2_n     (slv_cs2_n)
);

// File: tb/lnk_pwrseq_tb_top.sv
module lnk_pwrseq_tb_top;

    localparam int DW    = 16;
    localparam int LOCK  = 64;
    localparam int PRE   = 11;
    localparam int CMC   = 7;
    localparam int PGW   = 17;
    localparam int T_HI  = LOCK + PRE;
    localparam int T_ZR  = LOCK + 2 * PRE;
    localparam int T_RUN = LOCK + 3 * PRE;
    localparam int T_CAL = LOCK + PRE + 1;
    localparam int T_CLK = T_RUN + 1 + 2 * (CMC - 1);
    localparam int T_UP  = T_CLK + PGW;

    localparam logic [1:0] OFF = 2'b00;
    localparam logic [1:0] LO  = 2'b01;
    localparam logic [1:0] HI  = 2'b10;

    logic clk = 1'b0;
    logic rst, pd_n, act_valid, cut;
    logic [1:0] act_md;
    logic [1:0] m_mc, m_md0, m_md1, m_phase, slv_mc_in;
    logic m_quiet_ok;
    logic [DW-1:0] up_data, slv_data;
    logic up_ad, up_cs1_n, up_cs2_n, up_rd_st, up_wr_st;
    logic slv_cal_latch, slv_refclk, slv_pgood;
    logic slv_ad, slv_cs1_n, slv_cs2_n, slv_rd_st, slv_wr_st;
    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = !clk;

    assign slv_mc_in = cut ? HI : m_mc;

    lnk_pwrseq #(.DATA_W(DW), .LOCK_CYC(LOCK)) dut_i (
        .clk(clk), .rst(rst), .pd_n(pd_n), .act_valid(act_valid), .act_md(act_md),
        .m_mc(m_mc), .m_md0(m_md0), .m_md1(m_md1), .m_phase(m_phase),
        .m_quiet_ok(m_quiet_ok), .slv_mc_in(slv_mc_in),
        .up_data(up_data), .up_ad(up_ad), .up_cs1_n(up_cs1_n), .up_cs2_n(up_cs2_n),
        .up_rd_st(up_rd_st), .up_wr_st(up_wr_st),
        .slv_cal_latch(slv_cal_latch), .slv_refclk(slv_refclk), .slv_pgood(slv_pgood),
        .slv_data(slv_data), .slv_ad(slv_ad), .slv_cs1_n(slv_cs1_n),
        .slv_cs2_n(slv_cs2_n), .slv_rd_st(slv_rd_st), .slv_wr_st(slv_wr_st)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_parked(input string req);
        chk(req, "parked data", 32'(slv_data), 32'h0);
        chk(req, "parked ctl", {27'h0, slv_ad, slv_cs1_n, slv_cs2_n, slv_rd_st, slv_wr_st},
            32'b01111);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pd_n = 1'b0; act_valid = 1'b0; act_md = 2'b00; cut = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        rst = 1'b1; pd_n = 1'b0; act_valid = 1'b0; act_md = 2'b00; cut = 1'b0;
        up_data = 16'hA5C3; up_ad = 1'b1; up_cs1_n = 1'b0; up_cs2_n = 1'b1;
        up_rd_st = 1'b0; up_wr_st = 1'b0;
        step(3);
        chk("R1", "lines", {26'h0, m_mc, m_md0, m_md1}, 32'h0);
        chk("R1", "phase", 32'(m_phase), 32'h0);
        chk("R1", "quiet/pgood/refclk", {29'h0, m_quiet_ok, slv_pgood, slv_refclk}, 32'h0);
        chk_parked("R1");
        rst = 1'b0;
        step(1);
    endtask

    // Full bring-up with exact-cycle checks; leaves the link up
    task automatic t_powerup();
        pd_n = 1'b1;
        for (int k = 1; k <= T_UP; k++) begin
            @(negedge clk);
            if (k == LOCK - 1) chk("R3", "mc before lock", 32'(m_mc), 32'(OFF));
            if (k == LOCK) begin
                chk("R3", "mc low after lock", 32'(m_mc), 32'(LO));
                chk("R4", "phase linkup", 32'(m_phase), 32'h1);
            end
            if (k == T_HI - 1) chk("R4", "mc low end", 32'(m_mc), 32'(LO));
            if (k == T_HI) chk("R4", "mc high md off", {26'h0, m_mc, m_md0, m_md1},
                               {26'h0, HI, OFF, OFF});
            if (k == T_ZR - 1) chk("R4", "mc high end", 32'(m_mc), 32'(HI));
            if (k == T_ZR) chk("R4", "all low", {26'h0, m_mc, m_md0, m_md1},
                               {26'h0, LO, LO, LO});
            if (k == T_RUN - 1) chk("R4", "zero step end", 32'(m_mc), 32'(LO));
            if (k == T_RUN) begin
                chk("R5", "run mc high", 32'(m_mc), 32'(HI));
                chk("R5", "phase idle", 32'(m_phase), 32'h2);
            end
            if (k == T_RUN + 1) chk("R5", "mc toggles", {28'h0, m_mc, m_md0},
                                    {28'h0, LO, LO});
            if (k == T_CAL - 1) chk("R8", "no cal yet", 32'(slv_cal_latch), 32'h0);
            if (k == T_CAL) chk("R8", "cal pulse", 32'(slv_cal_latch), 32'h1);
            if (k == T_CAL + 1) chk("R8", "cal ends", 32'(slv_cal_latch), 32'h0);
            if (k == T_CLK) chk("R9", "refclk idle", 32'(slv_refclk), 32'h0);
            if (k == T_CLK + 1) chk("R9", "refclk starts", 32'(slv_refclk), 32'h1);
            if (k == T_CLK + 2) chk("R9", "refclk toggles", 32'(slv_refclk), 32'h0);
            if (k == T_UP - 1) begin
                chk("R9", "pgood still low", 32'(slv_pgood), 32'h0);
                chk_parked("R11");
            end
            if (k == T_UP) chk("R9", "pgood high", 32'(slv_pgood), 32'h1);
        end
        chk("R11", "data passthrough", 32'(slv_data), 32'hA5C3);
        chk("R11", "ctl passthrough", {27'h0, slv_ad, slv_cs1_n, slv_cs2_n, slv_rd_st, slv_wr_st},
            32'b10100);
    endtask

    task automatic t_active();
        act_valid = 1'b1; act_md = 2'b10;
        step(1);
        chk("R6", "active md", {28'h0, m_md1, m_md0}, {28'h0, HI, LO});
        chk("R6", "phase active", 32'(m_phase), 32'h3);
        chk("R7", "quiet low active", 32'(m_quiet_ok), 32'h0);
        act_md = 2'b01;
        step(1);
        chk("R6", "active md swap", {28'h0, m_md1, m_md0}, {28'h0, LO, HI});
        act_valid = 1'b0;
        step(1);
        chk("R5", "back to idle", {26'h0, m_phase, m_md1, m_md0}, {26'h0, 2'b10, LO, LO});
        chk("R7", "quiet low early", 32'(m_quiet_ok), 32'h0);
        step(11);
        chk("R7", "quiet high", 32'(m_quiet_ok), 32'h1);
    endtask

    task automatic t_pd_drop();
        pd_n = 1'b0;
        #1;
        chk("R2", "lines off at once", {26'h0, m_mc, m_md0, m_md1}, 32'h0);
        chk("R10", "pgood drops at once", 32'(slv_pgood), 32'h0);
        step(1);
        chk("R2", "phase off", 32'(m_phase), 32'h0);
        chk_parked("R11");
    endtask

    task automatic t_abort();
        do_reset();
        pd_n = 1'b1;
        step(LOCK + 5);
        chk("R2", "mid preamble", 32'(m_phase), 32'h1);
        pd_n = 1'b0;
        step(2);
        pd_n = 1'b1;
        step(LOCK - 1);
        chk("R2", "restart lock off", 32'(m_mc), 32'(OFF));
        step(1);
        chk("R2", "restart mc low", 32'(m_mc), 32'(LO));
    endtask

    task automatic t_loss();
        do_reset();
        t_powerup();
        cut = 1'b1;
        step(4);
        chk("R10", "pgood holds briefly", 32'(slv_pgood), 32'h1);
        step(8);
        chk("R10", "pgood lost", 32'(slv_pgood), 32'h0);
        chk_parked("R11");
        cut = 1'b0;
    endtask

    initial begin
        #1_900_000;
        n_fail++;
        $display("FAIL watchdog: got hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_powerup();
        t_active();
        t_pd_drop();
        t_abort();
        t_loss();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule